// File: doc/BRIEF.md
# Tile Shape Configuration Controller

This block holds the shape of a small bank of two-dimensional tile registers: for each tile, the number of active rows and the number of active bytes per row. Software hands it a 64-byte configuration record, one beat of `BEAT_BYTES` bytes at a time. Once the last beat is in, the record is examined. A record naming the empty palette returns everything to the idle state and asks the tile datapath to clear its storage. A malformed record raises a fault and leaves the current shape untouched. Any other record is committed.

The committed shape drives a `configured_o` flag and per-tile row and byte-count buses into the tile datapath. The record can be read back beat by beat through a combinational read port. While the block is idle, the read port returns zeroes. A release command drops the configuration at any time, even partway through loading a record.

Top module: `tile_shape_cfg`

## Requirements
- R1: After reset, `configured_o` is 0, every shape field is 0, `fault_o` and `zero_tiles_o` are 0, and every read-back beat is 0.
- R2: A record is made of 64/`BEAT_BYTES` accepted writes, with idle cycles allowed between them. Write k carries record bytes k·`BEAT_BYTES` upward, and the lowest byte sits in the lowest bits. The result appears on the outputs one cycle after the clock edge that accepts the final write.
- R3: Record layout. Byte 0 is the palette. Tile t's bytes-per-row value is a 16-bit little-endian field in bytes 16+2t and 17+2t. Tile t's row count is byte 48+t. Every other byte is reserved.
- R4: A record with palette 1, every row count ≤ 16, every bytes-per-row value ≤ 64 and all reserved bytes zero is committed. `configured_o` becomes 1, tile t's row count appears on `tile_rows_o[5t+:5]`, and its bytes-per-row value appears on `tile_colb_o[7t+:7]`.
- R5: A record with a nonzero palette is rejected if its palette is above 1, or any row count is above 16, or any bytes-per-row value is above 64 (including any nonzero high byte), or any reserved byte is nonzero. A rejected record pulses `fault_o` high for one cycle and leaves the configuration and read-back unchanged.
- R6: A record with palette 0 enters the idle state whatever its other bytes hold. `configured_o` and all shape fields become 0, and `zero_tiles_o` pulses for one cycle.
- R7: `release_i` enters the idle state one cycle later and pulses `zero_tiles_o`. It also discards any partly received record, so the next write counts as byte 0 of a new record.
- R8: `rd_data_o` returns beat `rd_addr_i` of the committed record, with all reserved bytes zero. While the block is not configured, it returns all zeroes.
- R9: A row count of 16 and a bytes-per-row value of 64 are accepted. Values of 17 and 65 are rejected.
- R10: `fault_o` and `zero_tiles_o` are never high together, and each falls back to 0 in the cycle after its pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Accept one record beat |
| wdata_i | input | BEAT_BYTES*8 | Record beat data |
| release_i | input | 1 | Drop configuration and any partial record |
| rd_addr_i | input | IDX_W | Read-back beat index |
| rd_data_o | output | BEAT_BYTES*8 | Read-back beat data |
| configured_o | output | 1 | A valid shape is committed |
| fault_o | output | 1 | One-cycle pulse for a rejected record |
| zero_tiles_o | output | 1 | One-cycle request to clear all tile data |
| tile_rows_o | output | NUM_TILES*5 | Per-tile row count |
| tile_colb_o | output | NUM_TILES*7 | Per-tile bytes per row |

## Verification
The first sweep walks valid records whose row counts and byte widths step through every legal value across the tiles. Each one is read back beat by beat, which separates field placement errors from byte-order errors. A second sweep corrupts one reserved byte at a time, then each tile's row count, low width byte and high width byte in turn. This tells a missing range or reserved check apart from a wrong field offset, because the fault must fire while the earlier shape survives. Further records cover palettes above 1, a palette-0 record carrying junk, records sent with idle gaps, and a release that cuts a record short. These show whether the init path skips validation, whether gaps are tolerated, and whether the beat counter restarts after a release.

// File: rtl/tile_shape_pkg.sv
package tile_shape_pkg;
  localparam int REC_BYTES   = 64;
  localparam int REC_BITS    = REC_BYTES * 8;
  localparam int PAL_BYTE    = 0;
  localparam int COLB_BASE   = 16;
  localparam int ROWS_BASE   = 48;
  localparam int MAX_ROWS    = 16;
  localparam int MAX_COLB    = 64;
  localparam int MAX_PALETTE = 1;
  localparam int ROWS_W      = $clog2(MAX_ROWS + 1);
  localparam int COLB_W      = $clog2(MAX_COLB + 1);

  function automatic bit byte_is_field(int b, int nt);
    return (b == PAL_BYTE) ||
           (b >= COLB_BASE && b < COLB_BASE + 2 * nt) ||
           (b >= ROWS_BASE && b < ROWS_BASE + nt);
  endfunction
endpackage

// File: rtl/tile_shape_assembler.sv
module tile_shape_assembler
  import tile_shape_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  localparam int BEAT_BITS = BEAT_BYTES * 8,
  localparam int NUM_BEATS = REC_BYTES / BEAT_BYTES,
  localparam int IDX_W     = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flush_i,
  input  logic                 wr_i,
  input  logic [BEAT_BITS-1:0] wdata_i,
  output logic [REC_BITS-1:0]  rec_o,
  output logic                 rec_valid_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      rec_o       <= '0;
      rec_valid_o <= 1'b0;
    end else begin
      rec_valid_o <= 1'b0;
      if (flush_i) begin
        cnt_q <= '0;
      end else if (wr_i) begin
        rec_o[int'(cnt_q)*BEAT_BITS +: BEAT_BITS] <= wdata_i;
        if (cnt_q == IDX_W'(NUM_BEATS - 1)) begin
          cnt_q       <= '0;
          rec_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2: a complete record only follows an accepted, unflushed write
  a_r2_valid_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> ($past(wr_i) && !$past(flush_i)));
endmodule

// File: rtl/tile_shape_check.sv
module tile_shape_check
  import tile_shape_pkg::*;
#(
  parameter int NUM_TILES = 8
) (
  input  logic [REC_BITS-1:0]         rec_i,
  output logic [7:0]                  palette_o,
  output logic [NUM_TILES*ROWS_W-1:0] rows_o,
  output logic [NUM_TILES*COLB_W-1:0] colb_o,
  output logic                        init_o,
  output logic                        bad_o
);
  logic [NUM_TILES-1:0] tile_bad;
  logic [REC_BYTES-1:0] rsv_hit;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic [15:0] colb_raw;
    logic [7:0]  rows_raw;
    assign colb_raw    = rec_i[(COLB_BASE + 2*t)*8 +: 16];
    assign rows_raw    = rec_i[(ROWS_BASE + t)*8 +: 8];
    assign tile_bad[t] = (rows_raw > 8'(MAX_ROWS)) || (colb_raw > 16'(MAX_COLB));
    assign rows_o[t*ROWS_W +: ROWS_W] = rows_raw[ROWS_W-1:0];
    assign colb_o[t*COLB_W +: COLB_W] = colb_raw[COLB_W-1:0];
  end

  for (genvar b = 0; b < REC_BYTES; b++) begin : g_byte
    if (byte_is_field(b, NUM_TILES)) begin : g_fld
      assign rsv_hit[b] = 1'b0;
    end else begin : g_rsv
      assign rsv_hit[b] = |rec_i[b*8 +: 8];
    end
  end

  assign palette_o = rec_i[PAL_BYTE*8 +: 8];
  assign init_o    = (palette_o == 8'd0);
  assign bad_o     = !init_o &&
                     ((palette_o > 8'(MAX_PALETTE)) || (|tile_bad) || (|rsv_hit));
endmodule

// File: rtl/tile_shape_readback.sv
module tile_shape_readback
  import tile_shape_pkg::*;
#(
  parameter int NUM_TILES  = 8,
  parameter int BEAT_BYTES = 4,
  localparam int BEAT_BITS = BEAT_BYTES * 8,
  localparam int NUM_BEATS = REC_BYTES / BEAT_BYTES,
  localparam int IDX_W     = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
  input  logic                        configured_i,
  input  logic [7:0]                  palette_i,
  input  logic [NUM_TILES*ROWS_W-1:0] rows_i,
  input  logic [NUM_TILES*COLB_W-1:0] colb_i,
  input  logic [IDX_W-1:0]            addr_i,
  output logic [BEAT_BITS-1:0]        data_o
);
  logic [REC_BITS-1:0] img;

  always_comb begin
    img = '0;
    if (configured_i) begin
      img[PAL_BYTE*8 +: 8] = palette_i;
      for (int t = 0; t < NUM_TILES; t++) begin
        img[(COLB_BASE + 2*t)*8 +: 16] = 16'(colb_i[t*COLB_W +: COLB_W]);
        img[(ROWS_BASE + t)*8 +: 8]    = 8'(rows_i[t*ROWS_W +: ROWS_W]);
      end
    end
  end

  assign data_o = img[int'(addr_i)*BEAT_BITS +: BEAT_BITS];
endmodule

// File: rtl/tile_shape_cfg.sv
module tile_shape_cfg
  import tile_shape_pkg::*;
#(
  parameter int NUM_TILES  = 8,
  parameter int BEAT_BYTES = 4,
  localparam int BEAT_BITS = BEAT_BYTES * 8,
  localparam int NUM_BEATS = REC_BYTES / BEAT_BYTES,
  localparam int IDX_W     = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [BEAT_BITS-1:0]        wdata_i,
  input  logic                        release_i,
  input  logic [IDX_W-1:0]            rd_addr_i,
  output logic [BEAT_BITS-1:0]        rd_data_o,
  output logic                        configured_o,
  output logic                        fault_o,
  output logic                        zero_tiles_o,
  output logic [NUM_TILES*ROWS_W-1:0] tile_rows_o,
  output logic [NUM_TILES*COLB_W-1:0] tile_colb_o
);
  logic [REC_BITS-1:0]         rec;
  logic                        rec_valid;
  logic [7:0]                  chk_pal;
  logic [NUM_TILES*ROWS_W-1:0] chk_rows;
  logic [NUM_TILES*COLB_W-1:0] chk_colb;
  logic                        chk_init, chk_bad;
  logic [7:0]                  pal_q;

  tile_shape_assembler #(.BEAT_BYTES(BEAT_BYTES)) u_asm (
    .clk_i, .rst_ni, .flush_i(release_i), .wr_i, .wdata_i,
    .rec_o(rec), .rec_valid_o(rec_valid)
  );

  tile_shape_check #(.NUM_TILES(NUM_TILES)) u_chk (
    .rec_i(rec), .palette_o(chk_pal), .rows_o(chk_rows), .colb_o(chk_colb),
    .init_o(chk_init), .bad_o(chk_bad)
  );

  // release wins over a record completing in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      configured_o <= 1'b0;
      pal_q        <= '0;
      tile_rows_o  <= '0;
      tile_colb_o  <= '0;
      fault_o      <= 1'b0;
      zero_tiles_o <= 1'b0;
    end else begin
      fault_o      <= 1'b0;
      zero_tiles_o <= 1'b0;
      if (release_i || (rec_valid && chk_init)) begin
        configured_o <= 1'b0;
        pal_q        <= '0;
        tile_rows_o  <= '0;
        tile_colb_o  <= '0;
        zero_tiles_o <= 1'b1;
      end else if (rec_valid && chk_bad) begin
        fault_o <= 1'b1;
      end else if (rec_valid) begin
        configured_o <= 1'b1;
        pal_q        <= chk_pal;
        tile_rows_o  <= chk_rows;
        tile_colb_o  <= chk_colb;
      end
    end
  end

  tile_shape_readback #(.NUM_TILES(NUM_TILES), .BEAT_BYTES(BEAT_BYTES)) u_rb (
    .configured_i(configured_o), .palette_i(pal_q), .rows_i(tile_rows_o),
    .colb_i(tile_colb_o), .addr_i(rd_addr_i), .data_o(rd_data_o)
  );

  // R4 / R9: a committed shape stays inside tile capacity
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_sva
    a_r4_shape_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      configured_o |-> (tile_rows_o[t*ROWS_W +: ROWS_W] <= ROWS_W'(MAX_ROWS)) &&
                       (tile_colb_o[t*COLB_W +: COLB_W] <= COLB_W'(MAX_COLB)));
  end

  a_r5_fault_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(configured_o) && $stable(tile_rows_o) && $stable(tile_colb_o)));

  a_r6_zero_means_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_tiles_o |-> (!configured_o && tile_rows_o == '0 && tile_colb_o == '0));

  a_r7_release_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (zero_tiles_o && !configured_o));

  a_r8_idle_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !configured_o |-> (rd_data_o == '0));

  a_r10_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fault_o, zero_tiles_o}));
endmodule

// File: tb/tile_shape_cfg_tb_top.sv
module tile_shape_cfg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int BB = 4;
  localparam int NB = 64 / BB;
  localparam int BW = BB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0;
  logic [BW-1:0] wdata = '0;
  logic          rel = 1'b0;
  logic [3:0]    rd_addr = '0;
  logic [BW-1:0] rd_data;
  logic          configured, fault, zero_tiles;
  logic [NT*5-1:0] rows_o;
  logic [NT*7-1:0] colb_o;

  tile_shape_cfg #(.NUM_TILES(NT), .BEAT_BYTES(BB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .release_i(rel),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .configured_o(configured),
    .fault_o(fault), .zero_tiles_o(zero_tiles), .tile_rows_o(rows_o),
    .tile_colb_o(colb_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] rec [64];
  bit         m_cfg;
  logic [7:0] m_pal;
  int         m_rows [NT];
  int         m_colb [NT];
  bit         e_fault, e_zero;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_field(int b);
    return b == 0 || (b >= 16 && b < 16 + 2*NT) || (b >= 48 && b < 48 + NT);
  endfunction

  function automatic logic [7:0] exp_byte(int b);
    if (!m_cfg) return 8'h00;
    if (b == 0) return m_pal;
    if (b >= 16 && b < 16 + 2*NT) begin
      if (b % 2 == 0) return 8'(m_colb[(b-16)/2] % 256);
      return 8'(m_colb[(b-16)/2] / 256);
    end
    if (b >= 48 && b < 48 + NT) return 8'(m_rows[b-48]);
    return 8'h00;
  endfunction

  task automatic model_idle();
    m_cfg = 0; m_pal = 0;
    for (int t = 0; t < NT; t++) begin m_rows[t] = 0; m_colb[t] = 0; end
  endtask

  task automatic model_apply();
    bit bad;
    e_fault = 0; e_zero = 0;
    if (rec[0] == 0) begin
      model_idle(); e_zero = 1;
    end else begin
      bad = rec[0] > 1;
      for (int t = 0; t < NT; t++) begin
        if (rec[48+t] > 16) bad = 1;
        if ({rec[17+2*t], rec[16+2*t]} > 16'd64) bad = 1;
      end
      for (int b = 0; b < 64; b++) if (!is_field(b) && rec[b] != 0) bad = 1;
      if (bad) e_fault = 1;
      else begin
        m_cfg = 1; m_pal = rec[0];
        for (int t = 0; t < NT; t++) begin
          m_rows[t] = int'(rec[48+t]);
          m_colb[t] = int'({rec[17+2*t], rec[16+2*t]});
        end
      end
    end
  endtask

  task automatic clear_rec();
    for (int b = 0; b < 64; b++) rec[b] = 8'h00;
  endtask

  task automatic set_valid(int n);
    clear_rec();
    rec[0] = 8'd1;
    for (int t = 0; t < NT; t++) begin
      rec[48+t] = 8'((n + 3*t) % 17);
      rec[16+2*t] = 8'((5*n + 7*t) % 65);
    end
  endtask

  task automatic send_beats(int n, bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr = 1'b1;
      for (int k = 0; k < BB; k++) wdata[8*k +: 8] = rec[BB*i + k];
      if (gap) begin @(negedge clk); wr = 1'b0; end
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic check_state(string req);
    chk(req, "configured", longint'(configured), longint'(m_cfg));
    for (int t = 0; t < NT; t++) begin
      chk(req, "rows", longint'(rows_o[5*t +: 5]), longint'(m_rows[t]));
      chk(req, "colb", longint'(colb_o[7*t +: 7]), longint'(m_colb[t]));
    end
    for (int i = 0; i < NB; i++) begin
      logic [BW-1:0] e;
      @(negedge clk);
      rd_addr = 4'(i);
      #1;
      for (int k = 0; k < BB; k++) e[8*k +: 8] = exp_byte(BB*i + k);
      chk("R8", "readback", longint'(rd_data), longint'(e));
    end
  endtask

  // full record; outputs valid one cycle after the last accepted beat (R2)
  task automatic send_rec(string req, bit gap);
    send_beats(NB, gap);
    @(negedge clk);
    model_apply();
    chk(req, "fault pulse", longint'(fault), longint'(e_fault));
    chk(req, "zero pulse", longint'(zero_tiles), longint'(e_zero));
    @(negedge clk);
    chk("R10", "fault falls", longint'(fault), 0);
    chk("R10", "zero falls", longint'(zero_tiles), 0);
    check_state(req);
  endtask

  task automatic do_release();
    @(negedge clk); rel = 1'b1;
    @(negedge clk); rel = 1'b0;
    model_idle();
    chk("R7", "zero pulse", longint'(zero_tiles), 1);
    chk("R7", "configured", longint'(configured), 0);
    @(negedge clk);
    chk("R10", "zero falls", longint'(zero_tiles), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "fault", longint'(fault), 0);
    chk("R1", "zero", longint'(zero_tiles), 0);
    check_state("R1");

    // R3 R4 valid sweep across every legal value
    for (int n = 0; n < 24; n++) begin
      set_valid(n);
      send_rec("R4", n % 5 == 0);
    end

    // R9 limits accepted
    clear_rec(); rec[0] = 1;
    for (int t = 0; t < NT; t++) begin rec[48+t] = 8'd16; rec[16+2*t] = 8'd64; end
    send_rec("R9", 0);
    // R9 one over the limit, each tile; R5 high width byte
    for (int t = 0; t < NT; t++) begin
      set_valid(t); rec[48+t] = 8'd17; send_rec("R9", 0);
      set_valid(t); rec[16+2*t] = 8'd65; send_rec("R9", 0);
      set_valid(t); rec[17+2*t] = 8'd1; send_rec("R5", 0);
    end

    // R5 reserved bytes one at a time
    set_valid(7); send_rec("R4", 0);
    for (int b = 1; b < 64; b++) begin
      if (!is_field(b)) begin
        set_valid(9); rec[b] = 8'(b | 1); send_rec("R5", 0);
      end
    end
    // R5 unsupported palettes
    foreach (rec[i]) ;
    for (int p = 0; p < 4; p++) begin
      set_valid(11); rec[0] = (p == 0) ? 8'd2 : (p == 1) ? 8'd3 : (p == 2) ? 8'h80 : 8'hFF;
      send_rec("R5", 0);
    end

    // R6 palette zero with junk
    for (int b = 0; b < 64; b++) rec[b] = 8'((b * 37 + 5) % 256);
    rec[0] = 8'd0;
    send_rec("R6", 0);

    // R7 release while configured, while idle, and mid-record
    set_valid(13); send_rec("R4", 0);
    do_release(); check_state("R7");
    do_release(); check_state("R7");
    set_valid(4); send_beats(5, 0);
    do_release();
    set_valid(15); send_rec("R7", 0);
    chk("R7", "configured after restart", longint'(configured), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule